// File: doc/BRIEF.md
# Generator-Store Block Marshal Buffer

This block sits beside one core and keeps a short list of the cache blocks that the core's flagged producer stores have written. Each retiring store presents its physical address together with a flag that marks it as a producer of data for the next code segment. Only flagged stores are kept. Each one is reduced to its 64-byte block address, and a block already in the list is not added a second time.

When the core issues a marshal command naming a destination core, the block replays the list in the order the blocks were first recorded. It sends one block address per accepted beat on a valid/ready stream, and each beat carries the destination core ID. When the last beat is taken, it raises a one-cycle completion pulse and empties the list. Stores and new marshal commands are held back while a replay is running. A buffer that fills up drops further new blocks and raises a sticky overflow flag until the next replay completes.

Top module: `marshal_buf`

## Requirements
- R1: The buffer records at most DEPTH (default 16) distinct block addresses; a replay never emits more than DEPTH beats.
- R2: A store accepted with `st_gen` low is not recorded and never shows up in a later replay.
- R3: A recorded entry is the store address with its low log2(BLK_BYTES) bits (6 bits by default) cleared; `out_addr` carries the upper bits unchanged and zeros below.
- R4: A flagged store whose block matches an entry already held adds no entry. This holds even when the buffer is full, and in that case it does not set `overflow`.
- R5: A flagged store of a new block while the buffer holds DEPTH entries is dropped and sets `overflow`, visible the cycle after the store is accepted.
- R6: A marshal command is accepted while `mar_ready` is high. From the next cycle, `out_valid` presents the entries oldest first, one per cycle in which `out_ready` is high, with `out_dest` equal to the accepted `mar_dest`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_dest` hold steady.
- R8: From the cycle after a non-empty marshal is accepted until its completion, `st_ready` and `mar_ready` are low, so stores and commands wait.
- R9: In the cycle after the last beat is accepted, `mar_done` is high for one cycle. The buffer is then empty and `overflow` is clear.
- R10: A marshal accepted while the buffer is empty and no store is being recorded emits no beat, and `mar_done` is high in the next cycle.
- R11: A flagged store and a marshal accepted in the same cycle are both taken; the store's block, if new, is the last beat of that replay.
- R12: After reset, `out_valid`, `mar_done` and `overflow` are low, and `st_ready` and `mar_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A retiring store is presented |
| st_gen | input | 1 | Store is flagged as a producer for the next segment |
| st_addr | input | PADDR_W | Physical store address |
| st_ready | output | 1 | Store accepted this cycle when high |
| mar_valid | input | 1 | Marshal command presented |
| mar_dest | input | CORE_W | Destination core ID |
| mar_ready | output | 1 | Marshal command accepted this cycle when high |
| mar_done | output | 1 | One-cycle pulse when a marshal completes |
| out_valid | output | 1 | Block beat available |
| out_ready | input | 1 | Receiver takes the beat |
| out_addr | output | PADDR_W | Block-aligned physical address |
| out_dest | output | CORE_W | Destination core of the beat |
| overflow | output | 1 | Sticky: a new block was dropped because the buffer was full |

## Verification
The bench builds the block with its defaults: 16 entries, 48-bit addresses, 64-byte blocks and a 4-bit core ID. With these values, sixteen distinct stores reach the full state, so the bench can drive the duplicate-when-full store, the drop with overflow, and a full-length replay with a stalled receiver in short runs. The 6-bit offset lets the bench send stores with different low address bits to one block, which exercises both alignment and duplicate merging.

// File: rtl/mb_pkg.sv
// Shared types for the marshal buffer.
package mb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } mb_state_e;
endpackage

// File: rtl/mb_cam.sv
// Ordered block-tag store with associative lookup.
// Entries are filled contiguously from index 0 in arrival order; cnt says how
// many are live. Assumes the caller asserts ins only for a new tag with room left.
module mb_cam #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 42,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             ins,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             hit,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] match;

    // Write the new tag into the next free slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (ins && cnt_q == CNT_W'(i)) tag_q[i] <= lk_tag;
        end
    end

    // Count of live entries: grows on insert, drops to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (ins) cnt_q <= cnt_q + 1'b1;
    end

    // One comparator per slot, qualified by the slot being live.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (CNT_W'(g) < cnt_q) && (tag_q[g] == lk_tag);
    end

    assign hit    = |match;
    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign rd_tag = tag_q[rd_idx];
    assign cnt    = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));                                    // R1
    AST_INS_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));          // R1
    AST_NO_DUP_INS: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> (!hit && !full));                                   // R4
endmodule

// File: rtl/mb_drain_ctl.sv
// Replay controller: accepts a marshal command, walks the entries oldest first
// and clears the store after the last beat. Assumes cnt is stable while draining,
// which holds because stores are held off outside the idle state.
module mb_drain_ctl
    import mb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CORE_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_valid,
    input  logic [CORE_W-1:0] mar_dest,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ins,
    input  logic              out_ready,
    output logic              idle,
    output logic              out_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [CORE_W-1:0] dest,
    output logic              clr,
    output logic              done
);
    mb_state_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CORE_W-1:0] dest_q;
    logic              done_q;
    logic              go_empty, go_drain, last_beat;

    // Decode command acceptance and the final beat.
    always_comb begin
        go_empty  = (state_q == ST_IDLE) && mar_valid && (cnt == '0) && !ins;
        go_drain  = (state_q == ST_IDLE) && mar_valid && !((cnt == '0) && !ins);
        last_beat = (state_q == ST_DRAIN) && out_ready &&
                    ((CNT_W'(idx_q) + 1'b1) == cnt);
    end

    // State, read pointer, destination and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            dest_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= go_empty || last_beat;
            if (go_drain) begin
                state_q <= ST_DRAIN;
                idx_q   <= '0;
                dest_q  <= mar_dest;
            end else if (last_beat) begin
                state_q <= ST_IDLE;
                idx_q   <= '0;
            end else if (state_q == ST_DRAIN && out_ready) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idle      = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DRAIN);
    assign rd_idx    = idx_q;
    assign dest      = dest_q;
    assign clr       = last_beat;
    assign done      = done_q;

    AST_IDX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (CNT_W'(idx_q) < cnt));           // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));                           // R9
endmodule

// File: rtl/marshal_buf.sv
// Per-core marshal buffer. Captures the block addresses of flagged stores
// without duplicates and replays them to a chosen core on command.
// Assumes the store port honours st_ready and the command port honours mar_ready.
module marshal_buf #(
    parameter int PADDR_W   = 48,
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 16,
    parameter int CORE_W    = 4,
    localparam int OFF_W = $clog2(BLK_BYTES),
    localparam int TAG_W = PADDR_W - OFF_W,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic               st_gen,
    input  logic [PADDR_W-1:0] st_addr,
    output logic               st_ready,
    input  logic               mar_valid,
    input  logic [CORE_W-1:0]  mar_dest,
    output logic               mar_ready,
    output logic               mar_done,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PADDR_W-1:0] out_addr,
    output logic [CORE_W-1:0]  out_dest,
    output logic               overflow
);
    logic             hit, full, ins, clr, idle, capture;
    logic [TAG_W-1:0] rd_tag;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rd_idx;
    logic             ovf_q;

    // Qualify a flagged store and decide whether it becomes a new entry.
    always_comb begin
        capture = st_valid && st_ready && st_gen;
        ins     = capture && !hit && !full;
    end

    mb_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cam (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_tag (st_addr[PADDR_W-1:OFF_W]),
        .ins    (ins),
        .clr    (clr),
        .rd_idx (rd_idx),
        .hit    (hit),
        .rd_tag (rd_tag),
        .cnt    (cnt),
        .full   (full)
    );

    mb_drain_ctl #(.DEPTH(DEPTH), .CORE_W(CORE_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mar_valid (mar_valid),
        .mar_dest  (mar_dest),
        .cnt       (cnt),
        .ins       (ins),
        .out_ready (out_ready),
        .idle      (idle),
        .out_valid (out_valid),
        .rd_idx    (rd_idx),
        .dest      (out_dest),
        .clr       (clr),
        .done      (mar_done)
    );

    // Sticky drop flag, cleared when a replay empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_q <= 1'b0;
        else if (clr)                        ovf_q <= 1'b0;
        else if (capture && !hit && full)    ovf_q <= 1'b1;
    end

    assign st_ready  = idle;
    assign mar_ready = idle;
    assign out_addr  = {rd_tag, {OFF_W{1'b0}}};
    assign overflow  = ovf_q;

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_addr) && $stable(out_dest)));     // R7
    AST_STORE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!st_ready && !mar_ready));                   // R8
    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> full);                                     // R5
    AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mar_done |-> ((cnt == '0) && !ovf_q));                      // R9
endmodule

// File: tb/tb_marshal_buf.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, a requirement-level model of the list.
module tb_marshal_buf;
    localparam int PW = 48;
    localparam int OW = 6;
    localparam int DP = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_gen = 1'b0;
    logic [PW-1:0] st_addr = '0;
    logic          st_ready;
    logic          mar_valid = 1'b0;
    logic [CW-1:0] mar_dest = '0;
    logic          mar_ready, mar_done;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [PW-1:0] out_addr;
    logic [CW-1:0] out_dest;
    logic          overflow;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [PW-OW-1:0] exp_tag [DP];
    int exp_n = 0;
    bit exp_ovf = 0;

    always #2.5 clk = ~clk;

    marshal_buf dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_gen(st_gen), .st_addr(st_addr), .st_ready(st_ready),
        .mar_valid(mar_valid), .mar_dest(mar_dest), .mar_ready(mar_ready), .mar_done(mar_done),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_dest(out_dest),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
        end
    endtask

    // Present one store, wait for acceptance, update the model at the edge.
    task automatic do_store(input logic [PW-1:0] a, input bit g);
        bit found;
        st_valid = 1'b1; st_gen = g; st_addr = a;
        do @(negedge clk); while (!st_ready);
        @(posedge clk);
        if (g) begin
            found = 0;
            for (int i = 0; i < exp_n; i++) if (exp_tag[i] == a[PW-1:OW]) found = 1;
            if (!found) begin
                if (exp_n < DP) begin exp_tag[exp_n] = a[PW-1:OW]; exp_n++; end
                else exp_ovf = 1;
            end
        end
        #1;
        st_valid = 1'b0; st_gen = 1'b0;
        chk(overflow == exp_ovf, "R5 overflow after store", 64'(overflow), 64'(exp_ovf));
    endtask

    // Issue a marshal and check every beat, optionally stalling the receiver.
    task automatic do_marshal(input logic [CW-1:0] d, input bit stall);
        int n; int cyc;
        mar_valid = 1'b1; mar_dest = d;
        do @(negedge clk); while (!mar_ready);
        @(posedge clk); #1;
        mar_valid = 1'b0;
        n = exp_n;
        if (n == 0) begin
            chk(mar_done == 1'b1, "R10 done after empty marshal", 64'(mar_done), 64'd1);
            chk(out_valid == 1'b0, "R10 no beat on empty marshal", 64'(out_valid), 64'd0);
            @(posedge clk); #1;
            chk(mar_done == 1'b0, "R10 done is one cycle", 64'(mar_done), 64'd0);
            return;
        end
        chk(n <= DP, "R1 replay length bound", 64'(n), 64'(DP));
        for (int i = 0; i < n; i++) begin
            cyc = 0;
            forever begin
                out_ready = stall ? (cyc % 2 == 1) : 1'b1;
                chk(out_valid == 1'b1, "R6 beat valid", 64'(out_valid), 64'd1);
                chk(out_addr == {exp_tag[i], {OW{1'b0}}}, "R6 R3 beat address order",
                    64'(out_addr), 64'({exp_tag[i], {OW{1'b0}}}));
                chk(out_dest == d, "R6 beat destination", 64'(out_dest), 64'(d));
                chk(!st_ready && !mar_ready, "R8 inputs held during replay",
                    64'({st_ready, mar_ready}), 64'd0);
                chk(mar_done == 1'b0, "R9 no early done", 64'(mar_done), 64'd0);
                @(posedge clk); #1;
                if (out_ready) break;
                chk(out_valid && out_addr == {exp_tag[i], {OW{1'b0}}}, "R7 stalled beat held",
                    64'(out_addr), 64'({exp_tag[i], {OW{1'b0}}}));
                cyc++;
            end
        end
        out_ready = 1'b0;
        chk(mar_done == 1'b1, "R9 done after last beat", 64'(mar_done), 64'd1);
        chk(overflow == 1'b0, "R9 overflow cleared", 64'(overflow), 64'd0);
        chk(out_valid == 1'b0, "R9 stream idle after done", 64'(out_valid), 64'd0);
        exp_n = 0; exp_ovf = 0;
        @(posedge clk); #1;
        chk(mar_done == 1'b0, "R9 done is one cycle", 64'(mar_done), 64'd0);
    endtask

    task automatic t_reset();
        chk(!out_valid && !mar_done && !overflow, "R12 reset outputs low",
            64'({out_valid, mar_done, overflow}), 64'd0);
        chk(st_ready && mar_ready, "R12 ready after reset", 64'({st_ready, mar_ready}), 64'd3);
    endtask

    task automatic t_basic();
        do_store(48'h0000_1234_5678, 1);
        do_store(48'h0000_0000_00FF, 1);
        do_store(48'hABCD_EF01_2345, 1);
        do_marshal(4'd5, 0);
    endtask

    task automatic t_nongen();
        do_store(48'h0000_0000_1000, 0);
        do_store(48'h0000_0000_2040, 1);
        do_store(48'h0000_0000_3000, 0);
        do_store(48'h0000_0000_4080, 1);
        do_marshal(4'd2, 0);   // R2 only flagged blocks replayed
    endtask

    task automatic t_dup();
        do_store(48'h0000_0001_0000, 1);
        do_store(48'h0000_0001_003F, 1);   // R4 same block
        do_store(48'h0000_0002_0000, 1);
        do_store(48'h0000_0001_0010, 1);   // R4 same block
        do_marshal(4'd9, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DP; i++) do_store(48'(64'h10_0000 + i * 64 + i), 1);
        do_store(48'h0000_0010_0080, 1);   // R4 duplicate at full, no overflow
        chk(overflow == 1'b0, "R4 duplicate at full keeps overflow low", 64'(overflow), 64'd0);
        do_store(48'h0000_0099_0000, 1);   // R5 new block at full
        chk(overflow == 1'b1, "R5 overflow set when full", 64'(overflow), 64'd1);
        do_store(48'h0000_0000_0000, 0);
        chk(overflow == 1'b1, "R5 overflow sticky", 64'(overflow), 64'd1);
        do_marshal(4'd15, 1);              // R1 sixteen beats, R7 with stalls
        do_marshal(4'd3, 0);               // R9 buffer empty afterwards
    endtask

    task automatic t_empty();
        do_marshal(4'd7, 0);
        do_store(48'h0000_0000_5000, 0);
        do_marshal(4'd7, 0);               // R2 non-flagged store leaves it empty
    endtask

    task automatic t_wait();
        do_store(48'h0000_0777_0000, 1);
        do_store(48'h0000_0777_1000, 1);
        fork
            do_marshal(4'd1, 1);
            begin #7; do_store(48'h0000_0888_0000, 1); end   // R8 waits for replay
        join
        do_marshal(4'd4, 0);
    endtask

    task automatic t_same();
        do_store(48'h0000_0ABC_0000, 1);
        fork
            do_store(48'h0000_0DEF_0040, 1);   // R11 taken with the command
            do_marshal(4'd6, 0);
        join
        chk(exp_n == 0, "R11 same-cycle store replayed", 64'(exp_n), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_nongen();
        t_dup();
        t_full();
        t_empty();
        t_wait();
        t_same();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule